// File: doc/BRIEF.md
# Serial ADC Conversion Sequencer

This block is the host-side master for a 12-bit serial ADC that takes an 8-bit command word per conversion. It creates the chip-select, serial clock and command data lines. It also collects each conversion result from the converter's data line and returns it to the requester together with the command word that produced it. The serial clock comes from the system clock through a parameterised divider. Command data changes on falling serial edges. Result data is sampled on rising serial edges.

After reset the sequencer holds chip select high for a power-on hold-off period. It then lowers chip select and keeps it low from that point on. The serial clock runs freely while chip select is low. Before the first command, the sequencer sends a flush of zero bits so that the converter sees a clean start bit. The sequencer then works in fixed frame slots. At each slot boundary it takes one command, if one is offered, and sends it MSB first, with the top bit forced to 1 because that bit is the start bit. If no command is offered at a boundary, the slot passes with the data line low.

A mode input sets the slot length. In the short mode a slot is 15 serial clocks, and the next command overlaps the last result bits of the previous conversion. In the aligned mode a slot is 16 serial clocks, so each frame is a whole number of bytes. Result capture runs independently of the slot in which it began, so a result can finish while the next command is already being sent.

Top module: `adc_frame_seq`

## Requirements
- R1: While reset is asserted, csN is 1, sclk is 0, mosi is 0, cmdReady is 0 and resValid is 0.
- R2: After reset is released, csN stays 1 and sclk stays 0 for HOLDOFF_CYCLES system clocks. Once csN goes low it never returns high.
- R3: Exactly 16 rising sclk edges, all with mosi low, come before the first start bit.
- R4: A command word is sent on the rising sclk edges of serial clocks 1 to 8 of its frame, MSB first. Bit 7 is always sent as 1 whatever cmdByte[7] was; bits 6..0 follow unchanged.
- R5: Each high phase and each low phase of sclk lasts HALF_DIV system clocks. mosi changes only in the cycle where sclk falls.
- R6: With modeAligned = 0, commands offered back to back start 15 serial clocks apart.
- R7: With modeAligned = 1, commands offered back to back start 16 serial clocks apart.
- R8: The 12 result bits are sampled from miso on the rising edges of serial clocks 9 to 20, counted from the start bit's clock as 1. The first bit sampled is resData[11].
- R9: Each result is presented on resData with a resValid pulse one cycle long. resCmd carries the command word as it was sent, with bit 7 set.
- R10: cmdReady is high for exactly one cycle at each frame boundary, in a cycle where sclk is about to fall. It is never high while csN is high. A boundary with no command sends only zeros and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeAligned | input | 1 | 0: 15-clock frames, 1: 16-clock frames; sampled at each frame boundary |
| cmdValid | input | 1 | A command word is offered |
| cmdByte | input | CMD_W | Command word; top bit replaced by the start bit |
| cmdReady | output | 1 | Frame boundary; the offered command is taken this cycle |
| csN | output | 1 | Chip select to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| resValid | output | 1 | One-cycle pulse: result available |
| resData | output | RES_W | Assembled conversion result |
| resCmd | output | CMD_W | Command word that requested this result |

## Verification
The bound checker checks a set of rules on every cycle: the quiet lines during hold-off, the fact that chip select never goes back high, the length of each serial clock phase, that mosi moves only with a falling clock, that the ready pulse sits on a falling clock, and that the result strobe is a single cycle wide. The bench scenarios are needed for the rest. These are the length of the flush, the forced start bit, the 15 and 16 clock spacing of back-to-back frames, the exact bit window in which results are sampled, the pairing of each result with its command, and quiet boundaries when no command is offered. A converter model in the bench answers each received command with a value computed from that command. A scoreboard compares every returned result in order.

// File: rtl/adc_frame_pkg.sv
`timescale 1ns/1ps
package adc_frame_pkg;

  // strobes passed from the frame control to the datapath
  typedef struct packed {
    logic riseTick;   // sclk rises at the next edge; sample miso now
    logic fallTick;   // sclk falls at the next edge; advance mosi
    logic loadCmd;    // frame boundary with a command taken
    logic capStart;   // first result bit of a frame is sampled now
  } seqStrobes_t;

  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_FLUSH = 2'd1,
    ST_RUN   = 2'd2
  } seqState_t;

endpackage

// File: rtl/adc_frame_ctrl.sv
`timescale 1ns/1ps
module adc_frame_ctrl
  import adc_frame_pkg::*;
#(
  parameter int HALF_DIV       = 4,
  parameter int HOLDOFF_CYCLES = 1000,
  parameter int FLUSH_CLKS     = 16,
  parameter int SHORT_FRAME    = 15,
  parameter int LONG_FRAME     = 16,
  parameter int CAP_SLOT       = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        modeAligned,
  input  logic        cmdValid,
  output logic        csN,
  output logic        sclk,
  output logic        cmdReady,
  output seqStrobes_t strb
);

  localparam int PH_W    = $clog2(HALF_DIV + 1);
  localparam int HO_W    = $clog2(HOLDOFF_CYCLES + 1);
  localparam int MAX_LEN = (FLUSH_CLKS > LONG_FRAME) ?
                           ((FLUSH_CLKS > SHORT_FRAME) ? FLUSH_CLKS : SHORT_FRAME) :
                           ((LONG_FRAME > SHORT_FRAME) ? LONG_FRAME : SHORT_FRAME);
  localparam int SLOT_W  = $clog2(MAX_LEN + 1);

  seqState_t         state;
  logic [HO_W-1:0]   holdCnt;
  logic [PH_W-1:0]   phaseCnt;
  logic              sclkReg;
  logic [SLOT_W-1:0] slot;
  logic [SLOT_W-1:0] lastSlot;
  logic              frameActive;

  logic tick, riseTick, fallTick, atEnd, boundary;

  assign tick     = (state != ST_HOLD) && (phaseCnt == PH_W'(HALF_DIV - 1));
  assign riseTick = tick && !sclkReg;
  assign fallTick = tick && sclkReg;
  assign atEnd    = (slot == lastSlot);
  assign boundary = fallTick && atEnd;

  assign cmdReady      = boundary;
  assign strb.riseTick = riseTick;
  assign strb.fallTick = fallTick;
  assign strb.loadCmd  = boundary && cmdValid;
  assign strb.capStart = riseTick && (state == ST_RUN) && frameActive &&
                         (slot == SLOT_W'(CAP_SLOT));

  assign csN  = (state == ST_HOLD);
  assign sclk = sclkReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_HOLD;
      holdCnt     <= '0;
      phaseCnt    <= '0;
      sclkReg     <= 1'b0;
      slot        <= '0;
      lastSlot    <= SLOT_W'(FLUSH_CLKS - 1);
      frameActive <= 1'b0;
    end else if (state == ST_HOLD) begin
      if (holdCnt == HO_W'(HOLDOFF_CYCLES - 1)) begin
        state <= ST_FLUSH;
      end else begin
        holdCnt <= holdCnt + 1'b1;
      end
    end else begin
      phaseCnt <= tick ? '0 : phaseCnt + 1'b1;
      if (tick) begin
        sclkReg <= ~sclkReg;
      end
      if (fallTick) begin
        if (atEnd) begin
          slot        <= '0;
          state       <= ST_RUN;
          lastSlot    <= modeAligned ? SLOT_W'(LONG_FRAME - 1) : SLOT_W'(SHORT_FRAME - 1);
          frameActive <= cmdValid;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/adc_frame_dp.sv
`timescale 1ns/1ps
module adc_frame_dp
  import adc_frame_pkg::*;
#(
  parameter int CMD_W = 8,
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobes_t      strb,
  input  logic [CMD_W-1:0] cmdByte,
  input  logic             miso,
  output logic             mosi,
  output logic             resValid,
  output logic [RES_W-1:0] resData,
  output logic [CMD_W-1:0] resCmd
);

  localparam int CNT_W = $clog2(RES_W + 1);
  localparam logic [CMD_W-1:0] START_MASK = {1'b1, {(CMD_W-1){1'b0}}};

  logic [CMD_W-1:0] txShift;
  logic [CMD_W-1:0] curCmd;
  logic [CMD_W-1:0] capCmd;
  logic [RES_W-1:0] capShift;
  logic [CNT_W-1:0] capCnt;
  logic [CMD_W-1:0] sentByte;

  assign sentByte = cmdByte | START_MASK;
  assign mosi     = txShift[CMD_W-1];

  // command shifter: loaded at a boundary, drains to zeros afterwards
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txShift <= '0;
      curCmd  <= '0;
    end else if (strb.fallTick) begin
      if (strb.loadCmd) begin
        txShift <= sentByte;
        curCmd  <= sentByte;
      end else begin
        txShift <= {txShift[CMD_W-2:0], 1'b0};
      end
    end
  end

  // result assembly, independent of the frame slot once started
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capShift <= '0;
      capCnt   <= '0;
      capCmd   <= '0;
      resValid <= 1'b0;
      resData  <= '0;
      resCmd   <= '0;
    end else begin
      resValid <= 1'b0;
      if (strb.riseTick) begin
        if (strb.capStart) begin
          capShift <= {capShift[RES_W-2:0], miso};
          capCnt   <= CNT_W'(1);
          capCmd   <= curCmd;
        end else if (capCnt != '0) begin
          capShift <= {capShift[RES_W-2:0], miso};
          if (capCnt == CNT_W'(RES_W - 1)) begin
            resValid <= 1'b1;
            resData  <= {capShift[RES_W-2:0], miso};
            resCmd   <= capCmd;
            capCnt   <= '0;
          end else begin
            capCnt <= capCnt + 1'b1;
          end
        end
      end
    end
  end

endmodule

// File: rtl/adc_frame_seq.sv
`timescale 1ns/1ps
module adc_frame_seq
  import adc_frame_pkg::*;
#(
  parameter int CMD_W          = 8,
  parameter int RES_W          = 12,
  parameter int HALF_DIV       = 4,
  parameter int HOLDOFF_CYCLES = 1000,
  parameter int FLUSH_CLKS     = 16,
  parameter int SHORT_FRAME    = 15,
  parameter int LONG_FRAME     = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             modeAligned,
  input  logic             cmdValid,
  input  logic [CMD_W-1:0] cmdByte,
  output logic             cmdReady,
  output logic             csN,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             resValid,
  output logic [RES_W-1:0] resData,
  output logic [CMD_W-1:0] resCmd
);

  seqStrobes_t strb;

  adc_frame_ctrl #(
    .HALF_DIV      (HALF_DIV),
    .HOLDOFF_CYCLES(HOLDOFF_CYCLES),
    .FLUSH_CLKS    (FLUSH_CLKS),
    .SHORT_FRAME   (SHORT_FRAME),
    .LONG_FRAME    (LONG_FRAME),
    .CAP_SLOT      (CMD_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeAligned(modeAligned),
    .cmdValid   (cmdValid),
    .csN        (csN),
    .sclk       (sclk),
    .cmdReady   (cmdReady),
    .strb       (strb)
  );

  adc_frame_dp #(
    .CMD_W(CMD_W),
    .RES_W(RES_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .cmdByte (cmdByte),
    .miso    (miso),
    .mosi    (mosi),
    .resValid(resValid),
    .resData (resData),
    .resCmd  (resCmd)
  );

endmodule

// File: rtl/adc_frame_chk.sv
`timescale 1ns/1ps
module adc_frame_chk #(
  parameter int HALF_DIV = 4
) (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic mosi,
  input logic cmdReady,
  input logic resValid
);

  logic [15:0] phaseLen;
  logic        prevSclk;
  logic        seenEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseLen <= '0;
      prevSclk <= 1'b0;
      seenEdge <= 1'b0;
    end else begin
      prevSclk <= sclk;
      if (sclk != prevSclk) begin
        phaseLen <= 16'd1;
        seenEdge <= 1'b1;
      end else begin
        phaseLen <= phaseLen + 16'd1;
      end
    end
  end

  p_quiet_holdoff_r2: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> (!sclk && !mosi));

  p_cs_stays_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> !csN);

  p_phase_len_r5: assert property (@(posedge clk) disable iff (!rstN)
    ((sclk != prevSclk) && seenEdge) |-> (phaseLen == 16'(HALF_DIV)));

  p_mosi_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    (mosi != $past(mosi)) |-> $fell(sclk));

  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    resValid |=> !resValid);

  p_ready_fall_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |=> ($fell(sclk) && !cmdReady));

  p_ready_active_r10: assert property (@(posedge clk) disable iff (!rstN)
    cmdReady |-> !csN);

endmodule

bind adc_frame_seq adc_frame_chk #(.HALF_DIV(HALF_DIV)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .csN     (csN),
  .sclk    (sclk),
  .mosi    (mosi),
  .cmdReady(cmdReady),
  .resValid(resValid)
);

// File: tb/tb_adc_frame_seq.sv
`timescale 1ns/1ps
module tb_adc_frame_seq;

  localparam int CLK_PERIOD = 10;
  localparam int HALF_DIV   = 2;
  localparam int HOLDOFF    = 40;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeAligned = 1'b0;
  logic        cmdValid = 1'b0;
  logic [7:0]  cmdByte = 8'h00;
  logic        cmdReady, csN, sclk, mosi, resValid;
  logic        miso = 1'b0;
  logic [11:0] resData;
  logic [7:0]  resCmd;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  typedef struct { logic [7:0] cmd; logic [11:0] data; } exp_t;
  exp_t       expQ[$];
  logic [7:0] adcExpQ[$];
  int         startRise[$];
  int         riseIdx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_seq #(
    .HALF_DIV(HALF_DIV),
    .HOLDOFF_CYCLES(HOLDOFF)
  ) dut (
    .clk(clk), .rstN(rstN), .modeAligned(modeAligned),
    .cmdValid(cmdValid), .cmdByte(cmdByte), .cmdReady(cmdReady),
    .csN(csN), .sclk(sclk), .mosi(mosi), .miso(miso),
    .resValid(resValid), .resData(resData), .resCmd(resCmd)
  );

  function automatic logic [11:0] adcVal(input logic [7:0] b);
    return {b, b[7:4]} ^ 12'h5A3;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // converter model: receives commands on rising sclk, answers on falling sclk
  initial begin
    int          rxCnt = 0;
    logic [7:0]  rxByte = '0;
    logic [11:0] txShift = '0;
    int          txLeft = 0;
    bit          txArm = 1'b0;
    logic [11:0] pend = '0;
    forever begin
      @(posedge sclk or negedge sclk);
      if (sclk) begin
        riseIdx++;
        if (rxCnt == 0) begin
          if (mosi) begin
            rxByte = 8'h01;
            rxCnt  = 1;
            startRise.push_back(riseIdx);
          end
        end else begin
          rxByte = {rxByte[6:0], mosi};
          rxCnt++;
          if (rxCnt == 8) begin
            rxCnt = 0;
            pend  = adcVal(rxByte);
            txArm = 1'b1;
            if (adcExpQ.size() == 0) begin
              chk(1'b0, "R4", "unexpected command word", rxByte, 0);
            end else begin
              logic [7:0] e;
              e = adcExpQ.pop_front();
              chk(rxByte == e, "R4", "command word on mosi", rxByte, e);
            end
          end
        end
      end else begin
        if (txArm) begin
          txShift = pend;
          txLeft  = 12;
          txArm   = 1'b0;
        end
        if (txLeft > 0) begin
          miso    = txShift[11];
          txShift = {txShift[10:0], 1'b0};
          txLeft--;
        end else begin
          miso = 1'b0;
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (resValid) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R10", "result with no command", resData, 0);
        end else begin
          exp_t e;
          e = expQ.pop_front();
          chk(resData == e.data, "R8", "result data", resData, e.data);
          chk(resCmd == e.cmd, "R9", "result command", resCmd, e.cmd);
        end
      end
    end
  end

  // driver: offer a command until the frame boundary takes it
  task automatic send(input logic [7:0] b);
    exp_t e;
    cmdValid = 1'b1;
    cmdByte  = b;
    forever begin
      @(negedge clk);
      if (cmdReady) break;
    end
    e.cmd  = b | 8'h80;
    e.data = adcVal(b | 8'h80);
    expQ.push_back(e);
    adcExpQ.push_back(b | 8'h80);
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic burst(input logic [7:0] b0, input int n, input int gap, input string req);
    int base;
    base = startRise.size();
    for (int i = 0; i < n; i++) send(b0 + 8'(i * 29));
    for (int w = 0; w < 400 && startRise.size() < base + n; w++) @(negedge clk);
    for (int i = 1; i < n; i++) begin
      int g;
      g = (startRise.size() > base + i) ? startRise[base+i] - startRise[base+i-1] : -1;
      chk(g == gap, req, "start spacing in serial clocks", g, gap);
    end
  endtask

  task automatic drain();
    for (int w = 0; w < 2000 && expQ.size() != 0; w++) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "ALL", "watchdog expired", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    int hold;
    int t0;
    int t1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(csN == 1'b1, "R1", "csN in reset", csN, 1);
    chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
    chk(mosi == 1'b0, "R1", "mosi in reset", mosi, 0);
    chk(cmdReady == 1'b0, "R1", "cmdReady in reset", cmdReady, 0);
    chk(resValid == 1'b0, "R1", "resValid in reset", resValid, 0);
    // first command offered from the start, bit 7 clear (R4 forcing)
    cmdValid = 1'b1;
    cmdByte  = 8'h25;
    rstN = 1'b1;
    // R2 hold-off length
    hold = 0;
    forever begin
      @(negedge clk);
      if (!csN) break;
      hold++;
    end
    chk(hold == HOLDOFF - 1, "R2", "negedges with csN high after release", hold, HOLDOFF - 1);
    chk(riseIdx == 0, "R2", "sclk rises during hold-off", riseIdx, 0);
    // R5 serial clock period
    @(posedge sclk); t0 = $time;
    @(posedge sclk); t1 = $time;
    chk((t1 - t0) == 2 * HALF_DIV * CLK_PERIOD, "R5", "sclk period ns",
        t1 - t0, 2 * HALF_DIV * CLK_PERIOD);
    send(8'h25);
    for (int w = 0; w < 200 && startRise.size() == 0; w++) @(negedge clk);
    // R3 flush: start bit on the 17th rising edge
    chk(startRise.size() > 0 && startRise[0] == 17, "R3", "rise index of first start",
        startRise.size() > 0 ? startRise[0] : -1, 17);
    // R6 overlapped frames
    modeAligned = 1'b0;
    burst(8'h11, 5, 15, "R6");
    drain();
    // R10 idle boundaries: no start bits, no results
    begin
      int s0;
      s0 = startRise.size();
      modeAligned = 1'b1;
      repeat (300) @(negedge clk);
      chk(startRise.size() == s0, "R10", "start bits with no command", startRise.size(), s0);
      chk(expQ.size() == 0, "R10", "pending results while idle", expQ.size(), 0);
    end
    // R7 aligned frames, including boundary command values
    burst(8'h00, 1, 0, "R7");
    burst(8'h7F, 4, 16, "R7");
    send(8'hFF);
    send(8'h80);
    drain();
    chk(expQ.size() == 0, "R9", "results outstanding at end", expQ.size(), 0);
    chk(adcExpQ.size() == 0, "R4", "commands not seen on mosi", adcExpQ.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule